// File: doc/BRIEF.md
# Event Counter Bank with Non-Destructive Query

This block keeps a bank of 32-bit event counters in RAM. Hardware event sources count by presenting a counter index on a bump stream. Each accepted bump adds one to that counter through a two-stage read-modify-write. A register port lets software read any counter without disturbing it and load any counter with a chosen value for debug. A counter that passes its largest value rolls over to zero.

Both input streams use valid/ready. An item is taken on a rising clock edge where both valid and ready are high. While the item is not taken, the source must hold valid and the item's fields steady. Ready depends only on the reset sweep: it is low while the bank is being cleared and high at all other times. Once the sweep is over, neither stream is ever stalled. Read responses come back on a plain valid pulse with no back-pressure.

When a bump and a register write land on the same counter, the bump wins and the write is dropped. A write is also dropped when a bump to that counter was accepted one cycle before, because that bump is still writing its result. Reset clears the bank by writing zero to one counter per cycle. A busy flag stays high for the whole sweep.

Top module: `stat_query_bank`

## Requirements
- R1: After reset is released, busy stays high for exactly NUM_CNT clock edges (1024 at default) and then stays low until the next reset. Every counter then reads 0.
- R2: While busy is high, bump_ready and reg_ready are low, and a bump or register access offered in that time has no effect on any counter.
- R3: A register write with reg_write=1 loads reg_wdata into the counter whose index is reg_addr[IDX_W+1:2] (bits 11:2 at default). The low two address bits are ignored. Reads accepted from the next cycle on return the new value.
- R4: A register read with reg_write=0 raises rd_valid for exactly one cycle, in the cycle after acceptance, with the counter's value on rd_data. rd_data holds its value while rd_valid is low, and the read leaves the counter unchanged.
- R5: An accepted bump adds 1 to the counter at bump_idx. Reads accepted in the bump's own cycle or the next cycle return the earlier value. Reads accepted two or more cycles later return the incremented value.
- R6: Bumps to the same counter in consecutive cycles are all counted, with no increment lost.
- R7: A counter holding 0xFFFFFFFF goes to 0 when bumped, with no saturation.
- R8: A register write is discarded if a bump to the same counter is accepted in the same cycle or in the cycle before. Writes to other counters in those cycles take effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| busy | output | 1 | High while the clearing sweep runs |
| bump_valid | input | 1 | Bump request present |
| bump_ready | output | 1 | Bump can be taken (low during sweep) |
| bump_idx | input | IDX_W (10) | Counter to increment |
| reg_valid | input | 1 | Register access present |
| reg_ready | output | 1 | Register access can be taken (low during sweep) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | IDX_W+2 (12) | Byte address, counter n at n*4 |
| reg_wdata | input | CNT_W (32) | Value loaded by a write |
| rd_valid | output | 1 | One-cycle pulse: read data present |
| rd_data | output | CNT_W (32) | Value of the counter that was read |

## Verification
A stale or corrupted stored count does not show at once. It surfaces only when software next reads that counter, one cycle after the read is accepted, so the bench reads back every counter after each phase. A broken forwarding path loses increments and shows up as a short count on a read issued two cycles after a run of same-index bumps. A wrong collision rule leaves the written value in place of old+1 at the next read. A sweep of the wrong length shows at once on busy, and a wrong clear shows on the first read of a counter that was never touched.

// File: rtl/stat_qry_pkg.sv
package stat_qry_pkg;
  localparam int unsigned DEF_NUM_CNT = 1024;
  localparam int unsigned DEF_CNT_W   = 32;

  typedef enum logic [0:0] {
    PH_CLEAR = 1'b0,
    PH_LIVE  = 1'b1
  } phase_e;
endpackage

// File: rtl/stat_ram.sv
// Counter storage: two synchronous read ports, two write ports.
// Write port B takes priority when both hit the same word.
module stat_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [W-1:0]  wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [W-1:0]  wb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wa_en) mem[wa_addr] <= wa_data;
    if (wb_en) mem[wb_addr] <= wb_data;
  end

  // read-before-write: a read sees the word as it was before this edge
  always_ff @(posedge clk) begin
    if (ra_en) ra_data <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    if (rb_en) rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/stat_sweep.sv
// Post-reset clearing walk: one zero written per cycle.
module stat_sweep
  import stat_qry_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic          clr_en,
  output logic [AW-1:0] clr_idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  phase_e        phase;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CLEAR;
      ptr   <= '0;
    end else if (phase == PH_CLEAR) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) phase <= PH_LIVE;
    end
  end

  assign busy    = (phase == PH_CLEAR);
  assign clr_en  = busy;
  assign clr_idx = ptr;
endmodule

// File: rtl/stat_bump_pipe.sv
// Two-stage increment: S1 issues the RAM read, S2 adds one and writes back.
// A same-index bump directly behind another takes the forwarded sum.
module stat_bump_pipe #(
  parameter int unsigned AW = 10,
  parameter int unsigned W  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] take_idx,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_q,
  output logic          wb_en,
  output logic [AW-1:0] wb_idx,
  output logic [W-1:0]  wb_val
);
  logic          s2_vld;
  logic [AW-1:0] s2_idx;
  logic          s2_fwd;
  logic [W-1:0]  s2_fwd_val;
  logic [W-1:0]  s2_base;
  logic [W-1:0]  s2_sum;

  assign rd_en   = take;
  assign rd_addr = take_idx;

  assign s2_base = s2_fwd ? s2_fwd_val : rd_q;
  assign s2_sum  = s2_base + W'(1);  // rolls over at the top

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld <= 1'b0;
      s2_fwd <= 1'b0;
    end else begin
      s2_vld <= take;
      s2_fwd <= take && s2_vld && (s2_idx == take_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (take) s2_idx <= take_idx;
    s2_fwd_val <= s2_sum;
  end

  assign wb_en  = s2_vld;
  assign wb_idx = s2_idx;
  assign wb_val = s2_sum;
endmodule

// File: rtl/stat_query_bank.sv
module stat_query_bank
  import stat_qry_pkg::*;
#(
  parameter int unsigned NUM_CNT  = DEF_NUM_CNT,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  localparam int unsigned IDX_W   = $clog2(NUM_CNT),
  localparam int unsigned ADDR_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              busy,
  input  logic              bump_valid,
  output logic              bump_ready,
  input  logic [IDX_W-1:0]  bump_idx,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data
);
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic             bump_take;
  logic             reg_take;
  logic [IDX_W-1:0] reg_idx;
  logic             rd_take;
  logic             wr_take;
  logic             wr_clash;
  logic             wr_commit;
  logic             p_rd_en;
  logic [IDX_W-1:0] p_rd_addr;
  logic [CNT_W-1:0] p_rd_q;
  logic             p_wb_en;
  logic [IDX_W-1:0] p_wb_idx;
  logic [CNT_W-1:0] p_wb_val;
  logic             wa_en;
  logic [IDX_W-1:0] wa_addr;
  logic [CNT_W-1:0] wa_data;

  stat_sweep #(.DEPTH(NUM_CNT)) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

  assign bump_ready = !busy;
  assign reg_ready  = !busy;

  assign bump_take = bump_valid && bump_ready;
  assign reg_take  = reg_valid && reg_ready;
  assign reg_idx   = reg_addr[ADDR_W-1:2];
  assign rd_take   = reg_take && !reg_write;
  assign wr_take   = reg_take && reg_write;

  // bump wins: drop a write aimed at a counter entering or leaving the pipe
  assign wr_clash  = (bump_take && (bump_idx == reg_idx)) ||
                     (p_wb_en && (p_wb_idx == reg_idx));
  assign wr_commit = wr_take && !wr_clash;

  stat_bump_pipe #(.AW(IDX_W), .W(CNT_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .take     (bump_take),
    .take_idx (bump_idx),
    .rd_en    (p_rd_en),
    .rd_addr  (p_rd_addr),
    .rd_q     (p_rd_q),
    .wb_en    (p_wb_en),
    .wb_idx   (p_wb_idx),
    .wb_val   (p_wb_val)
  );

  // port A serves the sweep while busy, register writes afterwards
  assign wa_en   = clr_en || wr_commit;
  assign wa_addr = clr_en ? clr_idx : reg_idx;
  assign wa_data = clr_en ? '0 : reg_wdata;

  stat_ram #(.DEPTH(NUM_CNT), .W(CNT_W)) u_ram (
    .clk     (clk),
    .ra_en   (p_rd_en),
    .ra_addr (p_rd_addr),
    .ra_data (p_rd_q),
    .rb_en   (rd_take),
    .rb_addr (reg_idx),
    .rb_data (rd_data),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wb_en   (p_wb_en),
    .wb_addr (p_wb_idx),
    .wb_data (p_wb_val)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_take;
  end
endmodule

// File: rtl/stat_query_bank_chk.sv
module stat_query_bank_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             bump_ready,
  input logic             reg_valid,
  input logic             reg_ready,
  input logic             reg_write,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rd_data
);
  // R2
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!bump_ready && !reg_ready));

  // R1
  sweep_once_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid == $past(reg_valid && reg_ready && !reg_write));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));
endmodule

bind stat_query_bank stat_query_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .bump_ready (bump_ready),
  .reg_valid  (reg_valid),
  .reg_ready  (reg_ready),
  .reg_write  (reg_write),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data)
);

// File: tb/tb_stat_query_bank.sv
`timescale 1ns/1ps
module tb_stat_query_bank;
  localparam int N  = 16;
  localparam int IW = $clog2(N);
  localparam int AW = IW + 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          busy;
  logic          bump_valid;
  logic          bump_ready;
  logic [IW-1:0] bump_idx;
  logic          reg_valid;
  logic          reg_ready;
  logic          reg_write;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic          rd_valid;
  logic [31:0]   rd_data;

  int applied = 0;
  int bad     = 0;

  logic [31:0] model [N];
  logic        pend_v = 1'b0;
  int          pend_i = 0;

  always #4 clk = ~clk;

  stat_query_bank #(.NUM_CNT(N), .CNT_W(32)) dut (
    .clk(clk), .rst(rst), .busy(busy),
    .bump_valid(bump_valid), .bump_ready(bump_ready), .bump_idx(bump_idx),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle, starting and ending on a falling edge
  task automatic step(input logic bv, input int bi, input logic rv,
                      input logic rw, input int ri, input logic [31:0] wd,
                      input string tag);
    logic [31:0] exp_rd;
    bump_valid = bv;
    bump_idx   = IW'(bi);
    reg_valid  = rv;
    reg_write  = rw;
    reg_addr   = AW'(ri * 4 + (ri % 4));  // R3: low bits vary, ignored
    reg_wdata  = wd;
    exp_rd     = model[ri];
    @(negedge clk);
    if (pend_v) model[pend_i] = model[pend_i] + 32'd1;
    if (rv && rw && !(bv && bi == ri) && !(pend_v && pend_i == ri))
      model[ri] = wd;
    pend_v = bv;
    pend_i = bi;
    if (rv && !rw) begin
      chk(rd_valid === 1'b1, tag, {31'd0, rd_valid}, 32'd1);
      chk(rd_data === exp_rd, tag, rd_data, exp_rd);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic rd(input int i, input string tag);
    step(0, 0, 1, 0, i, 0, tag);
  endtask

  task automatic wr(input int i, input logic [31:0] v);
    step(0, 0, 1, 1, i, v, "wr");
  endtask

  task automatic read_all(input string tag);
    idle(2);
    for (int i = 0; i < N; i++) rd(i, tag);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [31:0] held;
    for (int i = 0; i < N; i++) model[i] = 32'd0;
    rst = 1'b1; bump_valid = 0; bump_idx = 0; reg_valid = 0;
    reg_write = 0; reg_addr = 0; reg_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R2: ready low while busy; offered traffic must not land
    chk(busy === 1'b1, "R1 busy at release", {31'd0, busy}, 32'd1);
    chk(bump_ready === 1'b0 && reg_ready === 1'b0, "R2 ready low",
        {30'd0, bump_ready, reg_ready}, 32'd0);
    reg_valid = 1; reg_write = 1; reg_addr = AW'(3 * 4); reg_wdata = 32'hDEAD;
    bump_valid = 1; bump_idx = IW'(5);
    cnt = 0;
    while (busy === 1'b1 && cnt < 10 * N) begin
      @(negedge clk);
      cnt++;
    end
    reg_valid = 0; bump_valid = 0; reg_write = 0;
    // R1: sweep length
    chk(cnt == N, "R1 sweep length", 32'(cnt), 32'(N));
    idle(3);
    chk(busy === 1'b0, "R1 busy stays low", {31'd0, busy}, 32'd0);
    // R1 / R2: all zero, including counters touched during busy
    read_all("R1 R2 cleared");

    // R3: exhaustive write and read back
    for (int i = 0; i < N; i++) wr(i, 32'hA5A5_0000 ^ (32'h0101_0101 * 32'(i)));
    for (int i = 0; i < N; i++) rd(i, "R3 write readback");

    // R4: repeated read leaves value, data holds after the pulse
    rd(5, "R4 first read");
    rd(5, "R4 second read");
    held = rd_data;
    idle(1);
    chk(rd_valid === 1'b0, "R4 pulse one cycle", {31'd0, rd_valid}, 32'd0);
    chk(rd_data === held, "R4 data holds", rd_data, held);

    // R5: bump each counter, reads in same and next cycle see old value
    for (int i = 0; i < N; i++) begin
      step(1, i, 1, 0, i, 0, "R5 read same cycle");
      rd(i, "R5 read next cycle");
      rd(i, "R5 read after two");
    end

    // R6: back-to-back same index, then alternating pairs
    for (int k = 0; k < 10; k++) step(1, 7, 0, 0, 0, 0, "b");
    idle(2);
    rd(7, "R6 ten in a row");
    for (int k = 0; k < 8; k++) step(1, 2 + (k % 2), 1, 0, 12, 0, "R6 side read");
    for (int k = 0; k < 6; k++) step(1, 1, 1, 0, 1, 0, "R6 read during run");
    read_all("R6 totals");

    // R7: rollover
    wr(9, 32'hFFFF_FFFF);
    step(1, 9, 0, 0, 0, 0, "b");
    idle(2);
    rd(9, "R7 wrap to zero");
    chk(rd_data === 32'd0, "R7 wrap literal", rd_data, 32'd0);
    wr(10, 32'hFFFF_FFFE);
    step(1, 10, 0, 0, 0, 0, "b");
    step(1, 10, 0, 0, 0, 0, "b");
    step(1, 10, 0, 0, 0, 0, "b");
    idle(2);
    rd(10, "R7 wrap run");
    chk(rd_data === 32'd1, "R7 wrap run literal", rd_data, 32'd1);

    // R8: collision rules
    wr(4, 32'd100);
    step(1, 4, 1, 1, 4, 32'h5555, "R8 same cycle");
    idle(2);
    rd(4, "R8 same cycle result");
    chk(rd_data === 32'd101, "R8 same cycle literal", rd_data, 32'd101);
    wr(6, 32'd200);
    step(1, 6, 0, 0, 0, 0, "b");
    wr(6, 32'h7777);
    idle(2);
    rd(6, "R8 cycle after result");
    chk(rd_data === 32'd201, "R8 cycle after literal", rd_data, 32'd201);
    wr(11, 32'd300);
    step(1, 11, 0, 0, 0, 0, "b");
    idle(1);
    wr(11, 32'h1234);
    rd(11, "R8 two cycles after lands");
    step(1, 13, 1, 1, 14, 32'hCAFE, "R8 other index");
    step(1, 14, 1, 1, 13, 32'hBEEF, "R8 other index");
    read_all("R8 final bank");

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule